// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter Stage

This block is one stage of a synchronous binary counter with a parallel preset. Every state bit changes on the same rising clock edge. A direction input picks counting up or down. Two active-low enables must both be low for the count to move. If either enable is high, the stage holds its value.

A separate active-low terminal-count output lets stages be joined into a wider counter with no extra logic. Wire each stage's terminal-count output to the next stage's chain enable, and share one count enable across all stages. The terminal-count output is combinational, so it follows the chain enable, the direction and the stored count in the same cycle. A parameter adds a synchronous clear to zero for start-up; it is off by default.

Top module: `updn_stage`

## Requirements
- R1: When HAS_SRST is 1 and srst is high at a rising edge, q becomes zero after that edge. This takes priority over load and counting.
- R2: When ld_n is low at a rising edge, q takes the value of din after that edge, whatever the enable levels. No count step happens on that edge.
- R3: When ld_n is high and either cnt_en_n or chain_en_n is high at a rising edge, q keeps its value.
- R4: When ld_n is high, both enables are low and up is 1, q increases by one at the edge. The all-ones value wraps to zero.
- R5: When ld_n is high, both enables are low and up is 0, q decreases by one at the edge. Zero wraps to all ones.
- R6: tc_n is low exactly when chain_en_n is low and q is at its terminal value: all ones when up is 1, zero when up is 0. It follows a change on chain_en_n or up without waiting for a clock edge.
- R7: Changing ld_n, din, up or the enables between edges leaves q unchanged until the next rising edge, which uses only the levels present at that edge.
- R8: Three 4-bit stages form a 12-bit counter that matches a binary reference in both directions, across stage-boundary and full-width wraps. In this chain, each tc_n feeds the next chain_en_n and cnt_en_n is shared.
- R9: The stage runs this sequence: load 13; count up 14, 15, 0, 1, 2; hold at 2 while inhibited; count down 1, 0, 15, 14, 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous clear, active high; used only when HAS_SRST is 1 |
| ld_n | input | 1 | Synchronous parallel load, active low |
| din | input | WIDTH | Preset value |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| cnt_en_n | input | 1 | Count enable, active low, shared by all stages of a chain |
| chain_en_n | input | 1 | Chain enable, active low; also gates tc_n |
| q | output | WIDTH | Current count |
| tc_n | output | 1 | Terminal count, active low |

## Verification
Every instance in the bench uses WIDTH 4 and HAS_SRST 1. The clear gives a known starting state and a reset check, and the checker's disable condition has a defined source from the first edge. A lone stage covers the preset, inhibit, wrap and mid-cycle cases. Three stages chained to 12 bits reach the carry and borrow crossings between stages, including the all-ones to zero wrap of the full width.

// File: rtl/updn_stage.sv
module updn_stage #(
  parameter int WIDTH    = 4,
  parameter int HAS_SRST = 0
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             ld_n,
  input  logic [WIDTH-1:0] din,
  input  logic             up,
  input  logic             cnt_en_n,
  input  logic             chain_en_n,
  output logic [WIDTH-1:0] q,
  output logic             tc_n
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  logic             clr;
  logic             advance;
  logic [WIDTH-1:0] nxt;
  logic             at_end;

  assign clr     = (HAS_SRST != 0) && srst;
  assign advance = ~cnt_en_n & ~chain_en_n;
  assign nxt     = up ? q + ONE : q - ONE;
  assign at_end  = up ? (q == ALL_ONES) : (q == '0);
  assign tc_n    = ~(~chain_en_n & at_end);

  always_ff @(posedge clk) begin
    if (clr)          q <= '0;
    else if (!ld_n)   q <= din;
    else if (advance) q <= nxt;
  end
endmodule

// File: rtl/updn_stage_chk.sv
module updn_stage_chk #(
  parameter int WIDTH    = 4,
  parameter int HAS_SRST = 0
) (
  input logic             clk,
  input logic             srst,
  input logic             ld_n,
  input logic [WIDTH-1:0] din,
  input logic             up,
  input logic             cnt_en_n,
  input logic             chain_en_n,
  input logic [WIDTH-1:0] q,
  input logic             tc_n
);
  logic rst_e;
  assign rst_e = (HAS_SRST != 0) && srst;

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst_e)
    !ld_n |=> (q == $past(din)));  // R2

  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (rst_e)
    (ld_n && (cnt_en_n || chain_en_n)) |=> $stable(q));  // R3

  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst_e)
    (ld_n && !cnt_en_n && !chain_en_n && up) |=> (q == $past(q) + {{(WIDTH-1){1'b0}}, 1'b1}));  // R4

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst_e)
    (ld_n && !cnt_en_n && !chain_en_n && !up) |=> (q == $past(q) - {{(WIDTH-1){1'b0}}, 1'b1}));  // R5

  AST_TC_NEEDS_CHAIN: assert property (@(posedge clk) disable iff (rst_e)
    !tc_n |-> !chain_en_n);  // R6

  AST_TC_AT_ZERO_DOWN: assert property (@(posedge clk) disable iff (rst_e)
    (!chain_en_n && !up && (q == '0)) |-> !tc_n);  // R6
endmodule

bind updn_stage updn_stage_chk #(.WIDTH(WIDTH), .HAS_SRST(HAS_SRST)) chk_i (
  .clk(clk), .srst(srst), .ld_n(ld_n), .din(din), .up(up),
  .cnt_en_n(cnt_en_n), .chain_en_n(chain_en_n), .q(q), .tc_n(tc_n)
);

// File: tb/updn_stage_tb_top.sv
`timescale 1ns/1ps
module updn_stage_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       srst = 1'b1, ld_n = 1'b1, up = 1'b1, en_p = 1'b1, en_t = 1'b1;
  logic [3:0] din = '0, q;
  logic       tc_n;

  updn_stage #(.WIDTH(4), .HAS_SRST(1)) dut_i (
    .clk(clk), .srst(srst), .ld_n(ld_n), .din(din), .up(up),
    .cnt_en_n(en_p), .chain_en_n(en_t), .q(q), .tc_n(tc_n));

  logic        c_ld_n = 1'b1, c_up = 1'b1, c_en_p = 1'b1;
  logic [11:0] c_din = '0;
  logic [3:0]  cq0, cq1, cq2;
  logic        ctc0, ctc1, ctc2;

  updn_stage #(.WIDTH(4), .HAS_SRST(1)) st0_i (
    .clk(clk), .srst(srst), .ld_n(c_ld_n), .din(c_din[3:0]), .up(c_up),
    .cnt_en_n(c_en_p), .chain_en_n(1'b0), .q(cq0), .tc_n(ctc0));
  updn_stage #(.WIDTH(4), .HAS_SRST(1)) st1_i (
    .clk(clk), .srst(srst), .ld_n(c_ld_n), .din(c_din[7:4]), .up(c_up),
    .cnt_en_n(c_en_p), .chain_en_n(ctc0), .q(cq1), .tc_n(ctc1));
  updn_stage #(.WIDTH(4), .HAS_SRST(1)) st2_i (
    .clk(clk), .srst(srst), .ld_n(c_ld_n), .din(c_din[11:8]), .up(c_up),
    .cnt_en_n(c_en_p), .chain_en_n(ctc1), .q(cq2), .tc_n(ctc2));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    srst = 1'b1; step(); step();
    check("R1 q after clear", q, 0);
    check("R1 chain after clear", {cq2, cq1, cq0}, 0);
    check("R6 tc_n with chain high", tc_n, 1);
    srst = 1'b0;
  endtask

  task automatic t_load();
    ld_n = 1'b0; din = 4'd9; en_p = 1'b1; en_t = 1'b1; step();
    check("R2 load with enables high", q, 9);
    din = 4'd7; en_p = 1'b0; en_t = 1'b0; up = 1'b1; step();
    check("R2 load beats counting", q, 7);
    ld_n = 1'b1; en_p = 1'b1; en_t = 1'b1;
  endtask

  task automatic t_sequence();
    int ups[5]  = '{14, 15, 0, 1, 2};
    int dns[5]  = '{1, 0, 15, 14, 13};
    ld_n = 1'b0; din = 4'd13; step();
    check("R9 preset 13", q, 13);
    ld_n = 1'b1; up = 1'b1; en_p = 1'b0; en_t = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step();
      check("R4 R9 count up", q, ups[i]);
      if (ups[i] == 15) check("R6 tc_n at 15 up", tc_n, 0);
      else              check("R6 tc_n off terminal", tc_n, 1);
    end
    en_p = 1'b1; step(); step();
    check("R3 R9 hold with cnt_en_n high", q, 2);
    en_p = 1'b0; en_t = 1'b1; step();
    check("R3 hold with chain_en_n high", q, 2);
    en_t = 1'b0; up = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step();
      check("R5 R9 count down", q, dns[i]);
      if (dns[i] == 0) check("R6 tc_n at 0 down", tc_n, 0);
    end
    en_p = 1'b1; en_t = 1'b1;
  endtask

  task automatic t_comb_tc();
    ld_n = 1'b0; din = 4'd15; step(); ld_n = 1'b1;
    up = 1'b1; en_t = 1'b0; #1;
    check("R6 tc_n low at 15 up", tc_n, 0);
    up = 1'b0; #1;
    check("R6 tc_n follows up same cycle", tc_n, 1);
    up = 1'b1; en_t = 1'b1; #1;
    check("R6 tc_n follows chain_en_n", tc_n, 1);
  endtask

  task automatic t_midcycle();
    ld_n = 1'b0; din = 4'd3; step(); ld_n = 1'b1;
    #3; ld_n = 1'b0; din = 4'd11; #2;
    check("R7 no change mid-cycle on load", q, 3);
    ld_n = 1'b1; en_p = 1'b0; en_t = 1'b0; up = 1'b0; #2;
    en_p = 1'b1; up = 1'b1; #2;
    step();
    check("R7 only edge levels count", q, 3);
    en_p = 1'b0; en_t = 1'b0; #2; up = 1'b0; step();
    check("R7 direction at edge used", q, 2);
    en_p = 1'b1; en_t = 1'b1;
  endtask

  task automatic t_chain();
    logic [11:0] mdl;
    mdl = 12'hFFD; c_din = mdl; c_ld_n = 1'b0; step();
    check("R8 chain preset", {cq2, cq1, cq0}, mdl);
    c_ld_n = 1'b1; c_up = 1'b1; c_en_p = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (mdl == 12'hFFF) check("R8 top stage tc_n at full", ctc2, 0);
      step(); mdl = mdl + 12'd1;
      check("R8 chain up", {cq2, cq1, cq0}, mdl);
    end
    mdl = 12'h102; c_din = mdl; c_ld_n = 1'b0; step(); c_ld_n = 1'b1;
    c_up = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step(); mdl = mdl - 12'd1;
      check("R8 chain down over nibble borrow", {cq2, cq1, cq0}, mdl);
    end
    mdl = 12'h002; c_din = mdl; c_ld_n = 1'b0; step(); c_ld_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step(); mdl = mdl - 12'd1;
      check("R8 chain down over full wrap", {cq2, cq1, cq0}, mdl);
    end
    c_en_p = 1'b1; step();
    check("R8 chain hold", {cq2, cq1, cq0}, mdl);
  endtask

  initial begin
    t_reset();
    t_load();
    t_sequence();
    t_comb_tc();
    t_midcycle();
    t_chain();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule